// File: doc/BRIEF.md
# DC-Balanced Three-Lane Serial Encoder

The block takes a 21-bit parallel word and sends it over three single-bit serial data lanes, 7 bits per lane, plus a fourth lane that carries a framing clock pattern. Every output is a register clocked by the bit-rate clock. One word is taken per frame. The block raises a one-cycle take strobe, and the word present on the input at that clock edge is the one encoded.

In balanced mode each data lane keeps a running digital sum, counting a 1 as +1 and a 0 as -1. Before a group is sent, the lane compares the sign of the group's disparity with the sign of the running sum. It sends the group either unchanged or complemented, and adds a complementary pair of marker bits that tell the receiver which was done. A frame is then 9 bits long. The framing lane alternates between 4 and 5 high bits per frame, so it has no DC content either. In plain mode a frame is the bare 7 data bits with no markers and no balancing. The mode is read once per frame, at the take edge.

Top module: `dcb_serializer`

## Requirements
- R1: Lane i carries word bits [7i+6:7i]. In plain mode each frame is 7 bits long and sends the group unchanged, bit 0 first.
- R2: In balanced mode each frame is 9 bits long, sent in the order g0, g1, g2, g3, g4, A, g5, g6, B (first to last), where g is the group as sent.
- R3: Marker pair A=1, B=0 means g is the complement of the group. A=0, B=1 means g is the group unchanged.
- R4: With a running sum of zero the group is sent unchanged. Otherwise it is complemented exactly when its disparity (ones minus zeros over 7 bits) has the same sign as the running sum.
- R5: After a balanced frame the running sum grows by the disparity of the 9 bits sent, and its magnitude at frame boundaries never exceeds 7. A plain frame leaves the sum unchanged.
- R6: In balanced mode the framing lane sends 4 ones then 5 zeros, or 5 ones then 4 zeros. The two shapes alternate frame by frame.
- R7: In plain mode the framing lane sends 4 ones then 3 zeros, and the balanced alternation is held where it was.
- R8: `word_take` is high for one cycle per frame, every 9 cycles in balanced mode and every 7 in plain mode. It is first high in the first cycle after reset is released. Serial bit k of a frame appears on the outputs after the k-th clock edge following the take edge, and bit 0 appears at the take edge itself.
- R9: `balance_en` and `word_in` have no effect except at a take edge.
- R10: While reset is active all serial outputs are low. Reset clears every running sum and makes the next balanced frame on the framing lane the 4-high shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| balance_en | input | 1 | 1 selects balanced 9-bit frames, 0 selects plain 7-bit frames |
| word_in | input | 21 | Parallel word, sampled at the take edge |
| word_take | output | 1 | High in the cycle whose closing edge samples `word_in` |
| ser_data | output | 3 | Serial data lanes, bit i for group i |
| ser_clk | output | 1 | Framing clock lane |

## Verification
The bench drives runs of all-ones and all-zeros words, where every frame has disparity ±7. These push the running sum to its limit, and a design with the inversion sign test reversed would let the sum drift past 7 and show wrong markers at once. Random mode flips and new words on every cycle catch a design that reads the mode or the word in the middle of a frame, which would shorten frames or scramble bits. A reset in the middle of a run shows whether the sums and the framing phase return to their start values. Plain-mode stretches between balanced ones show whether a design wrongly advances the framing alternation or changes the sums during plain frames.

// File: rtl/dcb_pkg.sv
`timescale 1ns/1ps
package dcb_pkg;

    typedef enum logic {
        PH_SHORT = 1'b0,
        PH_LONG  = 1'b1
    } clk_phase_e;

    function automatic int frame_bits(input int grp_w);
        return grp_w + 2;
    endfunction

    function automatic int sum_bits(input int grp_w);
        return $clog2(grp_w + 1) + 2;
    endfunction

endpackage

// File: rtl/dcb_bit_seq.sv
`timescale 1ns/1ps
module dcb_bit_seq #(
    parameter int GRP_W = 7,
    localparam int FRAME_W = dcb_pkg::frame_bits(GRP_W),
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bal_in,
    output logic             load,
    output logic [CNT_W-1:0] pos
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bal;
    } seq_t;

    seq_t s_q, s_d;
    logic [CNT_W-1:0] last_pos;

    always_comb begin
        s_d      = s_q;
        last_pos = s_q.bal ? CNT_W'(FRAME_W - 1) : CNT_W'(GRP_W - 1);
        load     = (s_q.cnt == '0);
        if (load) begin
            s_d.bal = bal_in;
            s_d.cnt = CNT_W'(1);
        end else if (s_q.cnt == last_pos) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos = s_q.cnt;

    // R8: a take strobe never lasts two cycles
    a_r8_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R8: position never leaves the frame of the current mode
    a_r8_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(FRAME_W - 1) && (s_q.bal || s_q.cnt <= CNT_W'(GRP_W - 1)));

endmodule

// File: rtl/dcb_lane_enc.sv
`timescale 1ns/1ps
module dcb_lane_enc #(
    parameter int GRP_W = 7,
    localparam int FRAME_W = dcb_pkg::frame_bits(GRP_W),
    localparam int CNT_W = $clog2(FRAME_W),
    localparam int SUM_W = dcb_pkg::sum_bits(GRP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             bal_in,
    input  logic [CNT_W-1:0] pos,
    input  logic [GRP_W-1:0] grp,
    output logic             ser
);

    typedef struct packed {
        logic [FRAME_W-1:0]      frame;
        logic signed [SUM_W-1:0] rd;
        logic                    bit_out;
    } lane_t;

    lane_t s_q, s_d;

    int                      ones;
    logic signed [SUM_W-1:0] wd;
    logic signed [SUM_W-1:0] sent;
    logic                    inv;
    logic [GRP_W-1:0]        data;
    logic [FRAME_W-1:0]      bal_frame;
    logic [FRAME_W-1:0]      plain_frame;
    logic [FRAME_W-1:0]      new_frame;

    always_comb begin
        ones = 0;
        for (int k = 0; k < GRP_W; k++) ones = ones + int'(grp[k]);
        wd   = SUM_W'(2 * ones - GRP_W);
        inv  = (s_q.rd != '0) && (s_q.rd[SUM_W-1] == wd[SUM_W-1]);
        sent = inv ? -wd : wd;
        data = grp ^ {GRP_W{inv}};

        bal_frame = '0;
        for (int k = 0; k < GRP_W - 2; k++) bal_frame[k] = data[k];
        bal_frame[GRP_W-2]   = inv;
        bal_frame[GRP_W-1]   = data[GRP_W-2];
        bal_frame[GRP_W]     = data[GRP_W-1];
        bal_frame[GRP_W+1]   = ~inv;

        plain_frame          = '0;
        plain_frame[GRP_W-1:0] = grp;
        new_frame = bal_in ? bal_frame : plain_frame;

        s_d = s_q;
        if (load) begin
            s_d.frame   = new_frame;
            s_d.bit_out = new_frame[0];
            if (bal_in) s_d.rd = s_q.rd + sent;
        end else begin
            s_d.bit_out = s_q.frame[pos];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ser = s_q.bit_out;

    // R5: running sum stays within the group width
    a_r5_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rd <= SUM_W'(GRP_W)) && (s_q.rd >= -SUM_W'(GRP_W)));

    // R4: a positive sum always moves down after a balanced frame
    a_r4_pos_sum_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bal_in && s_q.rd > 0) |=> (s_q.rd < $past(s_q.rd)));

    // R4: a negative sum always moves up after a balanced frame
    a_r4_neg_sum_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bal_in && s_q.rd < 0) |=> (s_q.rd > $past(s_q.rd)));

    // R5: plain frames leave the sum alone
    a_r5_plain_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bal_in) |=> $stable(s_q.rd));

endmodule

// File: rtl/dcb_clk_lane.sv
`timescale 1ns/1ps
module dcb_clk_lane #(
    parameter int GRP_W = 7,
    localparam int FRAME_W = dcb_pkg::frame_bits(GRP_W),
    localparam int CNT_W = $clog2(FRAME_W),
    localparam int HI_SHORT = (FRAME_W - 1) / 2,
    localparam int HI_LONG = HI_SHORT + 1,
    localparam int HI_PLAIN = (GRP_W + 1) / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             bal_in,
    input  logic [CNT_W-1:0] pos,
    output logic             ser
);

    import dcb_pkg::*;

    typedef struct packed {
        clk_phase_e       phase;
        logic [CNT_W-1:0] hi;
        logic             bit_out;
    } clk_t;

    clk_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load) begin
            if (bal_in) begin
                s_d.hi    = (s_q.phase == PH_SHORT) ? CNT_W'(HI_SHORT) : CNT_W'(HI_LONG);
                s_d.phase = (s_q.phase == PH_SHORT) ? PH_LONG : PH_SHORT;
            end else begin
                s_d.hi = CNT_W'(HI_PLAIN);
            end
            s_d.bit_out = 1'b1;
        end else begin
            s_d.bit_out = (pos < s_q.hi);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: PH_SHORT, hi: '0, bit_out: 1'b0};
        else        s_q <= s_d;
    end

    assign ser = s_q.bit_out;

    // R6: every balanced frame flips the framing shape
    a_r6_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bal_in) |=> (s_q.phase != $past(s_q.phase)));

    // R7: plain frames keep the alternation where it was
    a_r7_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bal_in) |=> $stable(s_q.phase));

endmodule

// File: rtl/dcb_serializer.sv
`timescale 1ns/1ps
module dcb_serializer #(
    parameter int LANES = 3,
    parameter int GRP_W = 7,
    localparam int WORD_W = LANES * GRP_W,
    localparam int FRAME_W = dcb_pkg::frame_bits(GRP_W),
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              balance_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_take,
    output logic [LANES-1:0]  ser_data,
    output logic              ser_clk
);

    logic             load;
    logic [CNT_W-1:0] pos;

    dcb_bit_seq #(.GRP_W(GRP_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .bal_in (balance_en),
        .load   (load),
        .pos    (pos)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dcb_lane_enc #(.GRP_W(GRP_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .bal_in (balance_en),
            .pos    (pos),
            .grp    (word_in[i*GRP_W +: GRP_W]),
            .ser    (ser_data[i])
        );
    end

    dcb_clk_lane #(.GRP_W(GRP_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .bal_in (balance_en),
        .pos    (pos),
        .ser    (ser_clk)
    );

    assign word_take = load;

    // R8: the framing lane is high in the first bit of every frame
    a_r8_frame_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ser_clk);

endmodule

// File: tb/dcb_serializer_tb.sv
`timescale 1ns/1ps
module dcb_serializer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        balance_en = 1'b1;
    logic [20:0] word_in = '0;
    logic        word_take;
    logic [2:0]  ser_data;
    logic        ser_clk;

    int n_chk = 0;
    int n_fail = 0;

    // model state: entry = {balanced, clk lane, lane2, lane1, lane0}
    logic [4:0] q[$];
    logic [4:0] exp_v = '0;
    int         rd[3];
    bit         ph_long;

    always #4 clk = ~clk;

    dcb_serializer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .balance_en (balance_en),
        .word_in    (word_in),
        .word_take  (word_take),
        .ser_data   (ser_data),
        .ser_clk    (ser_clk)
    );

    task automatic chk(input bit ok, input string tag, input string ctx,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t: got %0h expected %0h", tag, ctx, $time, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic model_reset();
        q.delete();
        exp_v = '0;
        for (int l = 0; l < 3; l++) rd[l] = 0;
        ph_long = 1'b0;
    endtask

    // builds one frame from the requirements (R1-style mapping, R2 order, R3 markers, R4 rule)
    task automatic build(input logic [20:0] w, input logic m, input string ctx);
        logic [8:0] seq[3];
        int len;
        int hi;
        len = m ? 9 : 7;
        for (int l = 0; l < 3; l++) begin
            logic [6:0] g;
            int dsp;
            bit inv;
            g = w[7*l +: 7];
            dsp = 0;
            for (int b = 0; b < 7; b++) dsp += g[b] ? 1 : -1;
            if (m) begin
                inv = (rd[l] != 0) && ((rd[l] > 0) == (dsp > 0));
                if (inv) begin
                    g = ~g;
                    dsp = -dsp;
                end
                seq[l] = {~inv, g[6], g[5], inv, g[4:0]};
                rd[l] += dsp;
                chk(rd[l] <= 7 && rd[l] >= -7, "R5", ctx, rd[l], 7);
            end else begin
                seq[l] = {2'b00, g};
            end
        end
        if (m) begin
            hi = ph_long ? 5 : 4;
            ph_long = ~ph_long;
        end else begin
            hi = 4;
        end
        for (int k = 0; k < len; k++)
            q.push_back({m, (k < hi), seq[2][k], seq[1][k], seq[0][k]});
    endtask

    // called just after a falling edge
    task automatic tick(input logic [20:0] w, input logic m, input string ctx);
        chk(ser_data[0] == exp_v[0], exp_v[4] ? "R2" : "R1", ctx, ser_data[0], exp_v[0]);
        chk(ser_data[1] == exp_v[1], exp_v[4] ? "R2" : "R1", ctx, ser_data[1], exp_v[1]);
        chk(ser_data[2] == exp_v[2], exp_v[4] ? "R2" : "R1", ctx, ser_data[2], exp_v[2]);
        chk(ser_clk == exp_v[3], exp_v[4] ? "R6" : "R7", ctx, ser_clk, exp_v[3]);
        word_in = w;
        balance_en = m;
        #1;
        chk(word_take == (q.size() == 0), "R8", ctx, word_take, q.size() == 0);
        if (q.size() == 0) build(w, m, ctx);
        exp_v = q.pop_front();
        @(negedge clk);
    endtask

    // wkind: 0 random, 1 all ones, 2 all zeros; mkind: 0 plain, 1 balanced, 2 random each cycle
    task automatic run(input int n, input int wkind, input int mkind, input string ctx);
        for (int i = 0; i < n; i++) begin
            logic [20:0] w;
            logic m;
            w = (wkind == 0) ? 21'($urandom) : (wkind == 1) ? '1 : '0;
            m = (mkind == 2) ? 1'($urandom % 2) : 1'(mkind);
            tick(w, m, ctx);
        end
    endtask

    task automatic do_reset(input string ctx);
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(ser_data == 3'b000, "R10", ctx, ser_data, 0);
        chk(ser_clk == 1'b0, "R10", ctx, ser_clk, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R10 power-up");
        run(9 * 150, 0, 1, "R2 R3 R4 random balanced, word changes every cycle R9");
        run(9 * 20, 1, 1, "R3 R4 all ones");
        run(9 * 20, 2, 1, "R3 R4 all zeros");
        run(7 * 60, 0, 0, "R1 plain random");
        run(7 * 10, 1, 0, "R1 R7 plain all ones");
        run(9 * 30, 0, 1, "R5 R6 back to balanced");
        run(600, 0, 2, "R9 mode flips mid-frame");
        run(13, 1, 1, "R4 partial frame before reset");
        do_reset("R10 mid-run reset");
        run(9 * 20, 1, 1, "R10 R6 after reset");
        run(9 * 20, 0, 1, "R2 after reset");
        summary();
        $finish;
    end

endmodule